// File: doc/BRIEF.md
# Big-Endian Width-Adapting Transfer Sequencer

This block turns one internal transfer request of 1 to 32 bytes into a series of device-width beats on a 32-bit external address/data bus. The device width and the bus mode come from the configuration of the selected region, and they are supplied alongside the request. The block puts every beat on the byte lanes that the mode calls for. In the data lanes, the byte at the lowest address always appears on the most significant lane, whatever the internal byte order. On reads, the bytes returned by the device are collected into a 32-byte big-endian buffer. That buffer is handed back together with a one-cycle completion pulse.

Three bus modes are supported:
- **Multiplexed:** an address phase is followed by a data phase on the same pins, with an 8-, 16- or 32-bit device.
- **Split:** byte-wide data travels on the top lane while a 24-bit address is driven on the lower three lanes in the same cycle.
- **Alternate byte multiplexed:** an address phase is followed by byte-wide data on the bottom lane.

Chip-select decode and access timing belong to the surrounding bus controller.

Top module: `gbus_beat_seq`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `done`, `addr_phase`, `data_phase`, `ad_oe` and `rd_data` are all zero.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. It then runs ceil(len/B) beats, where B is the beat size in bytes. Beat k has `beat_addr` equal to the request address plus k*B.
- R3: In multiplexed and alternate byte modes, each beat starts with one address-phase cycle in which `ad_out` is the beat address and `ad_oe` is 4'b1111. That cycle is followed by exactly one data-phase cycle.
- R4: In multiplexed mode (`region_mode` 0 or 3), `region_width` 0/1/2 selects B = 1/2/4, and code 3 also gives B = 4. The beat bytes occupy `ad_out[31:24]`, then `[23:16]`, and so on, lowest address first. Write lanes are enabled with 4'b1000, 4'b1100 or 4'b1111, and unused lanes read zero.
- R5: In split mode (`region_mode` 1), a beat is a single data-phase cycle. `ad_out[31:24]` carries the data byte and `ad_out[23:0]` carries the low 24 address bits. `ad_oe` is 4'b1111 on writes and 4'b0111 on reads.
- R6: In alternate byte mode (`region_mode` 2), the data byte travels on `ad_out[7:0]` with `ad_out[31:8]` zero. `ad_oe` is 4'b0001 on writes.
- R7: Split and alternate byte modes always use B = 1, whatever the value of `region_width`.
- R8: Write data and read results are big-endian: byte i of the request is `req_wdata[255-8i -: 8]` or `rd_data[255-8i -: 8]`. Read bytes are taken from the same lanes that a write would use. `rd_data` is cleared when a request is accepted, and bytes at index len or above stay zero.
- R9: `done` (with `busy` still high) is high for exactly one cycle, the cycle after the last data phase. `busy` falls in the next cycle. During the data phase of a multiplexed or alternate byte read, `ad_oe` is 4'b0000.
- R10: `req_valid` and all request inputs are ignored while `busy` is high. A running transfer keeps its latched request, and no new request starts from them.
- R11: When len is not a multiple of B, the lanes of the final write beat that lie past the last requested byte are driven as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start byte address |
| req_len | input | 6 | Byte count, 1 to 32 |
| req_wdata | input | 256 | Write bytes, big-endian |
| region_mode | input | 2 | 0 multiplexed, 1 split, 2 alternate byte, 3 as 0 |
| region_width | input | 2 | Device width code for multiplexed mode |
| ad_in | input | 32 | Bus pins as seen from outside, sampled at the end of read data phases |
| ad_out | output | 32 | Value driven on the bus |
| ad_oe | output | 4 | Per-lane drive enable, bit 3 for `[31:24]` |
| addr_phase | output | 1 | Address phase in progress |
| data_phase | output | 1 | Data phase in progress |
| beat_addr | output | 32 | Byte address of the current beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 256 | Gathered read bytes, big-endian |

## Verification
Directed requests cover each mode and width pairing:
- A byte-wide multiplexed write proves the top-lane-first ordering.
- A 16-bit write of odd length catches a final beat that leaks stale bytes.
- A full-line 32-bit read separates correct lane gathering from byte-swapped gathering.
- Split and alternate byte transfers, run with a wide width code, show that the beat size is forced to one byte and that data moves to the other lanes.

Random requests with arbitrary addresses, lengths, modes and width codes then mix these cases. Some of them hold `req_valid` high with scrambled inputs while busy, to show that the latched request alone drives the beats.

// File: rtl/gbus_seq_pkg.sv
package gbus_seq_pkg;

  localparam int AD_W     = 32;
  localparam int AD_BYTES = AD_W / 8;

  localparam logic [1:0] MODE_MUX   = 2'd0;
  localparam logic [1:0] MODE_SPLIT = 2'd1;
  localparam logic [1:0] MODE_ALT8  = 2'd2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Bytes moved per beat for a mode and width code.
  function automatic logic [2:0] beat_bytes(input logic [1:0] mode, input logic [1:0] wcode);
    if (mode == MODE_SPLIT || mode == MODE_ALT8) return 3'd1;
    case (wcode)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/gbus_seq_ctrl.sv
module gbus_seq_ctrl
  import gbus_seq_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_mode,
  input  logic [1:0]        req_wcode,
  output phase_e            phase_o,
  output logic              start_o,
  output logic [LEN_W-1:0]  off_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              write_o,
  output logic [1:0]        mode_o,
  output logic [2:0]        wb_o
);

  phase_e            phase_q;
  logic [LEN_W-1:0]  off_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              write_q;
  logic [1:0]        mode_q;
  logic [2:0]        wb_q;
  logic [LEN_W:0]    next_off;
  logic              last_beat;

  assign start_o   = (phase_q == PH_IDLE) && req_valid;
  assign next_off  = {1'b0, off_q} + {{(LEN_W-2){1'b0}}, wb_q};
  assign last_beat = next_off >= {1'b0, len_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      off_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      write_q <= 1'b0;
      mode_q  <= MODE_MUX;
      wb_q    <= 3'd1;
    end else begin
      case (phase_q)
        PH_IDLE: if (req_valid) begin
          off_q   <= '0;
          addr_q  <= req_addr;
          len_q   <= req_len;
          write_q <= req_write;
          mode_q  <= req_mode;
          wb_q    <= beat_bytes(req_mode, req_wcode);
          phase_q <= (req_mode == MODE_SPLIT) ? PH_DATA : PH_ADDR;
        end
        PH_ADDR: phase_q <= PH_DATA;
        PH_DATA: begin
          if (last_beat) begin
            phase_q <= PH_DONE;
          end else begin
            off_q   <= next_off[LEN_W-1:0];
            addr_q  <= addr_q + ADDR_W'(wb_q);
            phase_q <= (mode_q == MODE_SPLIT) ? PH_DATA : PH_ADDR;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign off_o   = off_q;
  assign addr_o  = addr_q;
  assign len_o   = len_q;
  assign write_o = write_q;
  assign mode_o  = mode_q;
  assign wb_o    = wb_q;

  // R3
  addr_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADDR) |=> (phase_q == PH_DATA));

  // R2
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_ADDR || phase_q == PH_DATA) && $past(phase_q) == PH_DATA)
      |-> (addr_q == $past(addr_q) + ADDR_W'(wb_q)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

  // R9
  done_after_data_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DONE) |-> ($past(phase_q) == PH_DATA));

  // R5
  split_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ADDR) |-> (mode_q != MODE_SPLIT));

endmodule

// File: rtl/gbus_lane_place.sv
module gbus_lane_place
  import gbus_seq_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1,
  localparam int BUF_W     = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BUF_W-1:0]  req_wdata,
  input  phase_e            phase,
  input  logic [LEN_W-1:0]  off,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              write,
  input  logic [1:0]        mode,
  input  logic [2:0]        wb,
  output logic [AD_W-1:0]   ad_out,
  output logic [AD_BYTES-1:0] ad_oe
);

  logic [BUF_W-1:0] wdata_q;
  logic [BUF_W-1:0] shifted;
  logic [7:0]       wbyte [AD_BYTES];
  logic [AD_BYTES-1:0] width_mask;

  always_ff @(posedge clk) begin
    if (rst)        wdata_q <= '0;
    else if (start) wdata_q <= req_wdata;
  end

  assign shifted = wdata_q << {off, 3'b000};

  always_comb begin
    for (int j = 0; j < AD_BYTES; j++) begin
      if ((3'(j) < wb) && (({1'b0, off} + (LEN_W+1)'(j)) < {1'b0, len}))
        wbyte[j] = shifted[BUF_W-1-8*j -: 8];
      else
        wbyte[j] = 8'h00;
    end
  end

  always_comb begin
    case (wb)
      3'd1:    width_mask = 4'b1000;
      3'd2:    width_mask = 4'b1100;
      default: width_mask = 4'b1111;
    endcase
  end

  always_comb begin
    ad_out = '0;
    ad_oe  = '0;
    case (phase)
      PH_ADDR: begin
        ad_out = AD_W'(addr);
        ad_oe  = '1;
      end
      PH_DATA: begin
        if (mode == MODE_SPLIT) begin
          ad_out = {wbyte[0], addr[23:0]};
          ad_oe  = write ? 4'b1111 : 4'b0111;
        end else if (mode == MODE_ALT8) begin
          ad_out = {24'h0, wbyte[0]};
          ad_oe  = write ? 4'b0001 : 4'b0000;
        end else begin
          for (int j = 0; j < AD_BYTES; j++)
            ad_out[AD_W-1-8*j -: 8] = wbyte[j];
          ad_oe = write ? width_mask : 4'b0000;
        end
      end
      default: ;
    endcase
  end

  // R9
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && !write && mode != MODE_SPLIT) |-> (ad_oe == 4'b0000));

  // R6
  alt8_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && mode == MODE_ALT8) |-> (ad_out[31:8] == 24'h0));

  // R3
  addr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR) |-> (ad_oe == 4'b1111 && ad_out == AD_W'(addr)));

endmodule

// File: rtl/gbus_read_gather.sv
module gbus_read_gather
  import gbus_seq_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1,
  localparam int IDX_W     = $clog2(LINE_BYTES),
  localparam int BUF_W     = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  phase_e            phase,
  input  logic [LEN_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic              write,
  input  logic [1:0]        mode,
  input  logic [2:0]        wb,
  input  logic [AD_W-1:0]   ad_in,
  output logic [BUF_W-1:0]  rd_data
);

  logic [7:0]     rbuf [LINE_BYTES];
  logic [LEN_W:0] pos  [AD_BYTES];
  logic           hit  [AD_BYTES];
  logic [7:0]     lane [AD_BYTES];

  always_comb begin
    for (int j = 0; j < AD_BYTES; j++) begin
      pos[j] = {1'b0, off} + (LEN_W+1)'(j);
      hit[j] = (phase == PH_DATA) && !write && (3'(j) < wb) && (pos[j] < {1'b0, len});
      if (mode == MODE_SPLIT)     lane[j] = ad_in[AD_W-1 -: 8];
      else if (mode == MODE_ALT8) lane[j] = ad_in[7:0];
      else                        lane[j] = ad_in[AD_W-1-8*j -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      for (int i = 0; i < LINE_BYTES; i++) rbuf[i] <= 8'h00;
    end else begin
      for (int j = 0; j < AD_BYTES; j++)
        if (hit[j]) rbuf[pos[j][IDX_W-1:0]] <= lane[j];
    end
  end

  always_comb begin
    for (int i = 0; i < LINE_BYTES; i++)
      rd_data[BUF_W-1-8*i -: 8] = rbuf[i];
  end

  // R8
  clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> (rd_data == '0));

endmodule

// File: rtl/gbus_beat_seq.sv
module gbus_beat_seq
  import gbus_seq_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1,
  localparam int BUF_W     = 8 * LINE_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [BUF_W-1:0]    req_wdata,
  input  logic [1:0]          region_mode,
  input  logic [1:0]          region_width,
  input  logic [AD_W-1:0]     ad_in,
  output logic [AD_W-1:0]     ad_out,
  output logic [AD_BYTES-1:0] ad_oe,
  output logic                addr_phase,
  output logic                data_phase,
  output logic [ADDR_W-1:0]   beat_addr,
  output logic                busy,
  output logic                done,
  output logic [BUF_W-1:0]    rd_data
);

  phase_e            phase;
  logic              start;
  logic [LEN_W-1:0]  off;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  len;
  logic              write;
  logic [1:0]        mode;
  logic [2:0]        wb;

  gbus_seq_ctrl #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_mode(region_mode),
    .req_wcode(region_width), .phase_o(phase), .start_o(start), .off_o(off),
    .addr_o(addr), .len_o(len), .write_o(write), .mode_o(mode), .wb_o(wb)
  );

  gbus_lane_place #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_place (
    .clk(clk), .rst(rst), .start(start), .req_wdata(req_wdata), .phase(phase),
    .off(off), .addr(addr), .len(len), .write(write), .mode(mode), .wb(wb),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  gbus_read_gather #(.LINE_BYTES(LINE_BYTES)) u_gather (
    .clk(clk), .rst(rst), .start(start), .phase(phase), .off(off), .len(len),
    .write(write), .mode(mode), .wb(wb), .ad_in(ad_in), .rd_data(rd_data)
  );

  assign addr_phase = (phase == PH_ADDR);
  assign data_phase = (phase == PH_DATA);
  assign busy       = (phase != PH_IDLE);
  assign done       = (phase == PH_DONE);
  assign beat_addr  = addr;

  // R10
  hold_request_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$past(done)) |-> ($stable(len) && $stable(write) && $stable(mode)));

endmodule

// File: tb/gbus_beat_seq_test.sv
module gbus_beat_seq_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, req_write;
  logic [31:0]  req_addr;
  logic [5:0]   req_len;
  logic [255:0] req_wdata;
  logic [1:0]   region_mode, region_width;
  logic [31:0]  ad_in;
  logic [31:0]  ad_out;
  logic [3:0]   ad_oe;
  logic         addr_phase, data_phase, busy, done;
  logic [31:0]  beat_addr;
  logic [255:0] rd_data;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  gbus_beat_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .region_mode(region_mode), .region_width(region_width), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_phase(addr_phase), .data_phase(data_phase),
    .beat_addr(beat_addr), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int beat_w(input int mode, input int wc);
    if (mode == 1 || mode == 2) return 1;
    if (wc == 0) return 1;
    if (wc == 1) return 2;
    return 4;
  endfunction

  function automatic logic [255:0] rnd_line();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic run(input bit wr, input logic [31:0] a, input int len, input int mode,
                     input int wc, input logic [255:0] wd, input bit junk);
    int           wb = beat_w(mode, wc);
    int           off = 0;
    int           nbeats = 0;
    logic [255:0] ebuf = '0;
    logic [31:0]  ba, ead, m, rnd;
    logic [3:0]   eoe;
    logic [7:0]   eb [4];
    string        tg;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = 6'(len);
    req_wdata = wd; region_mode = 2'(mode); region_width = 2'(wc);
    @(negedge clk);
    // R10: scramble inputs after acceptance; optionally keep the strobe high
    req_valid = junk; req_write = ~wr; req_addr = $urandom; req_len = 6'd32;
    req_wdata = rnd_line(); region_mode = 2'((mode + 1) % 3); region_width = 2'd0;
    while (1) begin
      ba = a + 32'(off);
      if (mode != 1) begin
        chk(addr_phase && !data_phase, "R3 address phase flags", {addr_phase, data_phase}, 2'b10);
        chk(ad_out == ba && ad_oe == 4'hF, "R3 address phase bus", {ad_oe, ad_out}, {4'hF, ba});
        chk(beat_addr == ba, "R2 beat address", beat_addr, ba);
        @(negedge clk);
      end
      for (int j = 0; j < 4; j++)
        eb[j] = (j < wb && off + j < len) ? wd[255-8*(off+j) -: 8] : 8'h00;
      case (mode)
        1: begin ead = {eb[0], ba[23:0]}; eoe = wr ? 4'hF : 4'h7; tg = "R5 split"; end
        2: begin ead = {24'h0, eb[0]}; eoe = wr ? 4'h1 : 4'h0; tg = "R6 alt8"; end
        default: begin
          ead = {eb[0], eb[1], eb[2], eb[3]};
          eoe = wr ? (wb == 1 ? 4'h8 : (wb == 2 ? 4'hC : 4'hF)) : 4'h0;
          tg = "R4 mux";
        end
      endcase
      if (wr && off + wb > len) tg = "R11 partial final beat";
      m = {{8{eoe[3]}}, {8{eoe[2]}}, {8{eoe[1]}}, {8{eoe[0]}}};
      if (wr) m = '1;
      chk(data_phase && !addr_phase, {tg, " data phase flags"}, {addr_phase, data_phase}, 2'b01);
      chk(ad_oe == eoe, {tg, " lane enables"}, ad_oe, eoe);
      chk((ad_out & m) == (ead & m), {tg, " data lanes"}, ad_out & m, ead & m);
      chk(beat_addr == ba, "R2 beat address", beat_addr, ba);
      if (!wr) begin
        rnd = $urandom;
        ad_in = rnd;
        for (int j = 0; j < 4; j++)
          if (j < wb && off + j < len)
            ebuf[255-8*(off+j) -: 8] = (mode == 1) ? rnd[31:24] :
                                       (mode == 2) ? rnd[7:0] : rnd[31-8*j -: 8];
      end
      nbeats++;
      @(negedge clk);
      ad_in = '0;
      off += wb;
      if (off >= len) break;
    end
    req_valid = 1'b0;
    if (mode != 0) chk(nbeats == len, "R7 byte beats in narrow modes", nbeats, len);
    else           chk(nbeats == (len + wb - 1) / wb, "R2 beat count", nbeats, (len + wb - 1) / wb);
    chk(done && busy, "R9 done pulse", {done, busy}, 2'b11);
    chk(rd_data == ebuf, "R8 gathered read data", rd_data, ebuf);
    @(negedge clk);
    if (junk) chk(!done && !busy, "R10 no restart while busy", {done, busy}, 2'b00);
    else      chk(!done && !busy, "R9 done single cycle", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    req_wdata = '0; region_mode = '0; region_width = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && ad_oe == 4'h0 && !addr_phase && !data_phase, "R1 reset outputs",
        {busy, done, addr_phase, data_phase, ad_oe}, '0);
    chk(rd_data == '0, "R1 reset read buffer", rd_data, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && ad_oe == 4'h0, "R1 after release", {busy, done, ad_oe}, '0);

    run(1'b1, 32'h1FC0_0000, 5, 0, 0, rnd_line(), 1'b0);   // R4 byte mux write
    run(1'b1, 32'h0000_1002, 7, 0, 1, rnd_line(), 1'b0);   // R11 16-bit odd length
    run(1'b0, 32'h2000_0000, 32, 0, 2, '0, 1'b0);          // R8 full line read
    run(1'b1, 32'h0000_0010, 1, 0, 3, rnd_line(), 1'b0);   // R4 width code 3
    run(1'b0, 32'h00AB_CDE0, 3, 1, 2, '0, 1'b0);           // R5 R7 split read
    run(1'b1, 32'h0012_3456, 4, 1, 2, rnd_line(), 1'b0);   // R5 R7 split write
    run(1'b1, 32'h3000_0040, 2, 2, 1, rnd_line(), 1'b0);   // R6 alt8 write
    run(1'b0, 32'h3000_0080, 6, 2, 2, '0, 1'b0);           // R6 alt8 read
    run(1'b1, 32'h0000_0100, 9, 0, 2, rnd_line(), 1'b1);   // R10 strobe held
    run(1'b0, 32'h0000_0200, 13, 0, 1, '0, 1'b1);          // R10 on a read

    for (int n = 0; n < 60; n++)
      run(1'($urandom), $urandom, 1 + int'($urandom % 32), int'($urandom % 3),
          int'($urandom % 4), rnd_line(), 1'($urandom % 4 == 0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule